// File: doc/BRIEF.md
# Eight-Channel PWM Timebase with Conversion Trigger

This block runs one shared 15-bit up-counter that serves eight PWM channels. The counter climbs from zero to a programmed terminal value and then returns to zero. Each channel owns two compare values. A match on the first drives its output high, and a match on the second drives it low. Either match also latches a sticky per-channel event flag. Every return to zero latches a wrap flag. A programmable count value can produce a one-cycle start strobe for an external converter.

Software programs the block through a single-cycle register write strobe. Every write is accepted in the cycle it is presented, so the port has no ready signal and no back-pressure. The block carries no data stream, so every other pin is a plain level or a plain strobe.

Setting the run bit restarts the counter from zero. That restart latches the wrap flag at once, before any full period has run. Clearing the run bit freezes the counter where it stands. Flags are cleared by writing ones to a clear register, and a hardware set in the same cycle wins over the clear. A single interrupt line combines the channel flags with the wrap flag. The wrap flag only reaches that line through its own enable.

Top module: `octpwm_unit`

## Requirements
- R1: A write to address 0 with bit 0 set while the counter is stopped restarts it. After that edge `cnt_o` is 0 and every `pwm_o` bit equals the matching bit of the initial-level register (address 3, bits 7:0).
- R2: The restart edge of R1 sets `wrap_flag_o` in that same edge, with no full period elapsed.
- R3: A write to address 0 with bit 0 clear stops the counter. `cnt_o` and `pwm_o` then hold their values until the next restart.
- R4: While running, `cnt_o` advances by one each cycle. In the cycle after it equals the terminal value (address 1, bits 14:0) it reads 0, and that wrap sets `wrap_flag_o`.
- R5: `wrap_flag_o` is set by hardware whatever the wrap interrupt enable (address 0, bit 1) holds. The enable only gates whether the flag reaches `irq_o`.
- R6: For channel i, compare A sits at address 16+2i and compare B at address 17+2i. While running, if `cnt_o` equals A the output is high after the next edge. If it equals B the output is low after the next edge, and B wins when both match.
- R7: A compare A or B match sets bit i of `chan_flag_o`. The bit stays set until a write to address 4 with bit i set clears it (bit 8 of that write clears the wrap flag). A set in the same cycle as a clear wins.
- R8: `adc_start_o` pulses high for one cycle, in the cycle after `cnt_o` equals the trigger value (address 2). This needs the counter to be running, the link enable (address 0, bit 2) to be set, and both `adc_pwr_ok` and `adc_trig_ok` to be high.
- R9: `irq_o` is high exactly when any `chan_flag_o` bit is set, or when the wrap flag and the wrap interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 6 | Register address |
| wr_data | input | 15 | Register write data |
| adc_pwr_ok | input | 1 | Converter powered, from outside |
| adc_trig_ok | input | 1 | Converter accepts PWM starts, from outside |
| pwm_o | output | 8 | Channel outputs |
| cnt_o | output | 15 | Shared counter value |
| chan_flag_o | output | 8 | Sticky per-channel compare flags |
| wrap_flag_o | output | 1 | Sticky wrap flag |
| adc_start_o | output | 1 | One-cycle converter start strobe |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Random register traffic uses short terminal values and compare values that reach just past them. The channels therefore see matches on A only, on B only, on both at once, and on neither, and the results show whether low priority and the hold states are correct. Random run toggles separate a fresh restart, with its immediate wrap flag, from a stop that must freeze the count. Random clears that land on match cycles show whether a hardware set beats a software clear. Toggling the two converter-side enables and the link bit shows the start strobe firing only when all conditions line up.

// File: rtl/octpwm_pkg.sv
package octpwm_pkg;
  // Register map (word addresses)
  localparam int ADR_CTRL     = 0;
  localparam int ADR_TOP      = 1;
  localparam int ADR_TRIG     = 2;
  localparam int ADR_INIT     = 3;
  localparam int ADR_CLEAR    = 4;
  localparam int ADR_CMP_BASE = 16;
  // Control bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_WIE  = 1;
  localparam int CB_LINK = 2;
endpackage

// File: rtl/octpwm_regs.sv
module octpwm_regs
  import octpwm_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 15,
  parameter int AW  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  output logic                    run,
  output logic                    wrap_ie,
  output logic                    adc_link,
  output logic [CW-1:0]           top_val,
  output logic [CW-1:0]           trig_val,
  output logic [NCH-1:0]          init_lvl,
  output logic [NCH-1:0][CW-1:0]  cmp_a,
  output logic [NCH-1:0][CW-1:0]  cmp_b,
  output logic                    restart,
  output logic [NCH-1:0]          clr_chan,
  output logic                    clr_wrap
);
  logic wr_ctrl, wr_clear;

  assign wr_ctrl  = wr_en && (wr_addr == AW'(ADR_CTRL));
  assign wr_clear = wr_en && (wr_addr == AW'(ADR_CLEAR));
  assign restart  = wr_ctrl && wr_data[CB_RUN] && !run;
  assign clr_chan = wr_clear ? wr_data[NCH-1:0] : '0;
  assign clr_wrap = wr_clear && wr_data[NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      wrap_ie  <= 1'b0;
      adc_link <= 1'b0;
      top_val  <= '0;
      trig_val <= '0;
      init_lvl <= '0;
    end else if (wr_en) begin
      if (wr_ctrl) begin
        run      <= wr_data[CB_RUN];
        wrap_ie  <= wr_data[CB_WIE];
        adc_link <= wr_data[CB_LINK];
      end
      if (wr_addr == AW'(ADR_TOP))  top_val  <= wr_data;
      if (wr_addr == AW'(ADR_TRIG)) trig_val <= wr_data;
      if (wr_addr == AW'(ADR_INIT)) init_lvl <= wr_data[NCH-1:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    localparam int ADR_A = ADR_CMP_BASE + 2 * i;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_a[i] <= '0;
        cmp_b[i] <= '0;
      end else if (wr_en) begin
        if (wr_addr == AW'(ADR_A))     cmp_a[i] <= wr_data;
        if (wr_addr == AW'(ADR_A + 1)) cmp_b[i] <= wr_data;
      end
    end
  end

  // R1: a restart can only be requested while stopped; the run bit follows
  a_r1_run_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> run);
endmodule

// File: rtl/octpwm_timebase.sv
module octpwm_timebase #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [CW-1:0] top_val,
  input  logic [CW-1:0] trig_val,
  input  logic          adc_link,
  input  logic          adc_pwr_ok,
  input  logic          adc_trig_ok,
  input  logic          clr_wrap,
  output logic [CW-1:0] cnt,
  output logic          wrap_flag,
  output logic          adc_start
);
  logic at_top, wrap_evt, trig_hit;

  assign at_top   = (cnt == top_val);
  assign wrap_evt = restart || (run && at_top);
  assign trig_hit = run && adc_link && adc_pwr_ok && adc_trig_ok && (cnt == trig_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      wrap_flag <= 1'b0;
      adc_start <= 1'b0;
    end else begin
      if (restart)     cnt <= '0;
      else if (run)    cnt <= at_top ? '0 : cnt + CW'(1);
      wrap_flag <= (wrap_flag && !clr_wrap) || wrap_evt;
      adc_start <= trig_hit;
    end
  end

  a_r1_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
  a_r2_restart_flag: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> wrap_flag);
  a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt));
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && at_top) |=> (cnt == '0) && wrap_flag);
  a_r8_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !adc_start);
endmodule

// File: rtl/octpwm_channel.sv
module octpwm_channel #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic          init_lvl,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic          clr,
  output logic          pwm,
  output logic          flag
);
  logic hit_a, hit_b;

  assign hit_a = run && (cnt == cmp_a);
  assign hit_b = run && (cnt == cmp_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm  <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (restart)    pwm <= init_lvl;
      else if (hit_b) pwm <= 1'b0;
      else if (hit_a) pwm <= 1'b1;
      flag <= (flag && !clr) || hit_a || hit_b;
    end
  end

  a_r6_low_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b |=> !pwm);
  a_r6_high_on_a: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && !hit_b) |=> pwm);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  a_r3_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(pwm));
endmodule

// File: rtl/octpwm_unit.sv
module octpwm_unit #(
  parameter int NCH = 8,
  parameter int CW  = 15,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic           adc_pwr_ok,
  input  logic           adc_trig_ok,
  output logic [NCH-1:0] pwm_o,
  output logic [CW-1:0]  cnt_o,
  output logic [NCH-1:0] chan_flag_o,
  output logic           wrap_flag_o,
  output logic           adc_start_o,
  output logic           irq_o
);
  logic                   run, wrap_ie, adc_link, restart, clr_wrap;
  logic [CW-1:0]          top_val, trig_val;
  logic [NCH-1:0]         init_lvl, clr_chan;
  logic [NCH-1:0][CW-1:0] cmp_a, cmp_b;

  octpwm_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .wrap_ie(wrap_ie), .adc_link(adc_link), .top_val(top_val),
    .trig_val(trig_val), .init_lvl(init_lvl), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .restart(restart), .clr_chan(clr_chan), .clr_wrap(clr_wrap));

  octpwm_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .top_val(top_val),
    .trig_val(trig_val), .adc_link(adc_link), .adc_pwr_ok(adc_pwr_ok),
    .adc_trig_ok(adc_trig_ok), .clr_wrap(clr_wrap), .cnt(cnt_o),
    .wrap_flag(wrap_flag_o), .adc_start(adc_start_o));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    octpwm_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
      .init_lvl(init_lvl[i]), .cnt(cnt_o), .cmp_a(cmp_a[i]), .cmp_b(cmp_b[i]),
      .clr(clr_chan[i]), .pwm(pwm_o[i]), .flag(chan_flag_o[i]));
  end

  assign irq_o = (|chan_flag_o) || (wrap_flag_o && wrap_ie);

  // R5: with the enable off the wrap flag alone never raises the request
  a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_ie && chan_flag_o == '0) |-> !irq_o);
endmodule

// File: tb/octpwm_unit_tb_top.sv
module octpwm_unit_tb_top;
  localparam int NCH = 8, CW = 15, AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic adc_pwr_ok = 1'b0, adc_trig_ok = 1'b0;
  logic [NCH-1:0] pwm_o, chan_flag_o;
  logic [CW-1:0] cnt_o;
  logic wrap_flag_o, adc_start_o, irq_o;

  always #10 clk = ~clk;

  octpwm_unit #(.NCH(NCH), .CW(CW), .AW(AW)) dut_i (.*);

  int n_tests = 0, n_fail = 0;
  bit lockstep_on = 1'b0;

  // Reference model state, updated from the requirements
  logic [2:0] m_ctrl;
  logic [CW-1:0] m_top, m_trig, m_cnt;
  logic [NCH-1:0] m_init, m_pwm, m_cf;
  logic [CW-1:0] m_ca [NCH];
  logic [CW-1:0] m_cb [NCH];
  logic m_wf, m_adc;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic model_irq();
    return (m_cf != '0) || (m_wf && m_ctrl[1]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_top = '0; m_trig = '0; m_cnt = '0; m_init = '0;
      m_pwm = '0; m_cf = '0; m_wf = 1'b0; m_adc = 1'b0;
      for (int i = 0; i < NCH; i++) begin m_ca[i] = '0; m_cb[i] = '0; end
    end else begin
      logic run, rs, clrw;
      logic [NCH-1:0] clrc, np, hitset;
      run  = m_ctrl[0];
      rs   = wr_en && wr_addr == 0 && wr_data[0] && !run;
      clrc = (wr_en && wr_addr == 4) ? wr_data[NCH-1:0] : '0;
      clrw = wr_en && wr_addr == 4 && wr_data[NCH];
      m_adc = run && m_ctrl[2] && adc_pwr_ok && adc_trig_ok && m_cnt == m_trig;
      np = m_pwm; hitset = '0;
      for (int i = 0; i < NCH; i++) begin
        if (run && m_cnt == m_cb[i]) begin np[i] = 1'b0; hitset[i] = 1'b1; end
        else if (run && m_cnt == m_ca[i]) begin np[i] = 1'b1; hitset[i] = 1'b1; end
      end
      if (rs) np = m_init;
      m_wf = (m_wf && !clrw) || rs || (run && m_cnt == m_top);
      m_cf = (m_cf & ~clrc) | hitset;
      m_pwm = np;
      if (rs) m_cnt = '0;
      else if (run) m_cnt = (m_cnt == m_top) ? '0 : m_cnt + 1'b1;
      if (wr_en) begin
        case (int'(wr_addr))
          0: m_ctrl = wr_data[2:0];
          1: m_top  = wr_data;
          2: m_trig = wr_data;
          3: m_init = wr_data[NCH-1:0];
          default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
          if (int'(wr_addr) == 16 + 2 * i) m_ca[i] = wr_data;
          if (int'(wr_addr) == 17 + 2 * i) m_cb[i] = wr_data;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (lockstep_on && rst_n) begin
      chk("R4 counter", 32'(cnt_o), 32'(m_cnt));
      chk("R6 outputs", 32'(pwm_o), 32'(m_pwm));
      chk("R7 channel flags", 32'(chan_flag_o), 32'(m_cf));
      chk("R2 wrap flag", 32'(wrap_flag_o), 32'(m_wf));
      chk("R8 adc start", 32'(adc_start_o), 32'(m_adc));
      chk("R9 irq", 32'(irq_o), 32'(model_irq()));
    end
  end

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_0c71;
    void'($urandom(seed));
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 reset counter", 32'(cnt_o), 0);
    chk("R1 reset outputs", 32'(pwm_o), 0);
    chk("R9 reset irq", 32'(irq_o), 0);
    lockstep_on = 1'b1;

    // Directed: restart, compares, stop, clear
    wr(1, 10);
    wr(3, 'hA4);
    for (int i = 0; i < NCH; i++) begin wr(16 + 2 * i, 31); wr(17 + 2 * i, 31); end
    wr(16, 3); wr(17, 6);
    wr(0, 1);
    chk("R1 count after restart", 32'(cnt_o), 0);
    chk("R1 outputs at init", 32'(pwm_o), 'hA4);
    chk("R2 wrap flag at restart", 32'(wrap_flag_o), 1);
    chk("R5 flag without enable, no irq", 32'(irq_o), 0);
    idle(4);
    chk("R6 high after A", 32'(pwm_o[0]), 1);
    chk("R7 flag after A", 32'(chan_flag_o[0]), 1);
    idle(3);
    chk("R6 low after B", 32'(pwm_o[0]), 0);
    wr(4, 'h1FF);
    chk("R7 cleared", 32'(chan_flag_o), 0);
    chk("R7 wrap cleared", 32'(wrap_flag_o), 0);
    wr(0, 0);
    begin
      logic [CW-1:0] held;
      held = cnt_o;
      idle(5);
      chk("R3 count frozen", 32'(cnt_o), 32'(held));
    end
    wr(2, 2); adc_pwr_ok = 1'b1; adc_trig_ok = 1'b1;
    wr(0, 'b111);
    idle(3);
    chk("R8 start pulse", 32'(adc_start_o), 1);
    idle(1);
    chk("R8 single cycle", 32'(adc_start_o), 0);
    chk("R9 irq with wrap enabled", 32'(irq_o), 1);

    // Random phase
    for (int c = 0; c < 4000; c++) begin
      adc_pwr_ok  = ($urandom % 4) != 0;
      adc_trig_ok = ($urandom % 4) != 0;
      if ($urandom % 4 == 0) begin
        int sel, a, d;
        sel = $urandom % 8;
        case (sel)
          0: begin a = 0; d = (($urandom % 6) != 0) | (($urandom % 8) << 1); end
          1: begin a = 1; d = $urandom % 24; end
          2: begin a = 2; d = $urandom % 26; end
          3: begin a = 3; d = $urandom % 256; end
          4: begin a = 4; d = $urandom % 512; end
          default: begin a = 16 + ($urandom % 16); d = $urandom % 28; end
        endcase
        wr(a, d);
      end else begin
        idle(1);
      end
    end
    lockstep_on = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule